// File: doc/BRIEF.md
# Selectable YCbCr-to-RGB Color Converter

This block converts a stream of 8-bit YCbCr pixels into 8-bit RGB pixels. Each pixel enters with a valid strobe and leaves a fixed three clock cycles later with its own valid strobe. A new pixel can be accepted on every cycle.

Two select inputs choose the conversion matrix. One picks the colorimetry standard, BT.601 or BT.709. The other picks the input range: full range, where luma spans 0 to 255, or studio range, where luma spans 16 to 235. Both chroma channels are always centred by subtracting 128. Only studio range removes the luma offset of 16 and applies a luma gain; full range passes luma with unit gain.

The coefficients are signed fixed-point values with ten fraction bits, so each real coefficient is multiplied by 1024 and rounded to the nearest integer. Each channel is accumulated, then rounded to nearest, then saturated to the 8-bit range. The selects are sampled together with each pixel, so a pipeline may hold pixels converted under different matrices at the same time.

Top module: `ycc2rgb_conv`

## Requirements
- R1: While reset is asserted, and after reset until the first pixel result emerges, out_valid is 0.
- R2: out_valid equals in_valid from exactly three rising edges earlier. Back-to-back pixels produce back-to-back results in the same order.
- R3: Selects sel_709=0, sel_narrow=0 (BT.601 full range) apply luma gain 1024 with no offset. R uses +1404·Cr'. G uses −715·Cr' and −344·Cb'. B uses +1774·Cb'. Here Cr' = Cr−128 and Cb' = Cb−128.
- R4: Selects sel_709=0, sel_narrow=1 (BT.601 studio range) apply 1192·(Y−16). R uses +1634·Cr'. G uses −833·Cr' and −400·Cb'. B uses +2066·Cb'.
- R5: Selects sel_709=1, sel_narrow=0 (BT.709 full range) apply luma gain 1024 with no offset. R uses +1577·Cr'. G uses −470·Cr' and −187·Cb'. B uses +1860·Cb'.
- R6: Selects sel_709=1, sel_narrow=1 (BT.709 studio range) apply 1192·(Y−16). R uses +1836·Cr'. G uses −547·Cr' and −218·Cb'. B uses +2166·Cb'.
- R7: With Cb=Cr=128, the three outputs are equal in every mode. In full range they also equal Y.
- R8: Each channel sum gets 512 added and is then shifted right arithmetically by 10 bits, which rounds to nearest.
- R9: A rounded result below 0 is output as 0, and one above 255 is output as 255.
- R10: The selects are sampled on the same edge as the pixel. Changing them on every cycle converts each pixel with its own matrix.
- R11: While out_valid is 0, out_r, out_g and out_b keep their last values, whatever the inputs and selects do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid | input | 1 | Input pixel qualifier |
| in_y | input | 8 | Luma sample |
| in_cb | input | 8 | Blue-difference chroma sample |
| in_cr | input | 8 | Red-difference chroma sample |
| sel_709 | input | 1 | 0 = BT.601 matrix, 1 = BT.709 matrix |
| sel_narrow | input | 1 | 0 = full-range input, 1 = studio-range input |
| out_valid | output | 1 | Output pixel qualifier, three cycles after in_valid |
| out_r | output | 8 | Red result |
| out_g | output | 8 | Green result |
| out_b | output | 8 | Blue result |

## Verification
The assertions assume that in_valid is known from the first clock edge. They also assume that the pixel and select inputs hold known values on every edge where in_valid is high. Under those assumptions, the latency, grey-axis and luma pass-through properties compare outputs against inputs sampled three edges earlier. The stimulus drives every input to zero from time zero and holds reset across several edges. It then changes inputs only just after a falling edge, so every sampled value is defined and stable around the rising edge.

// File: rtl/ycc2rgb_pkg.sv
package ycc2rgb_pkg;

  // Container width for one fixed-point coefficient (enough for up to 12 fraction bits)
  localparam int COEF_W = 16;

  typedef logic signed [COEF_W-1:0] coef_t;

  // Mode encoding is {sel_709, sel_narrow}
  typedef enum logic [1:0] {
    CSC_601_FULL   = 2'b00,
    CSC_601_STUDIO = 2'b01,
    CSC_709_FULL   = 2'b10,
    CSC_709_STUDIO = 2'b11
  } csc_mode_e;

  typedef struct packed {
    coef_t ky;
    coef_t r_cr;
    coef_t g_cr;
    coef_t g_cb;
    coef_t b_cb;
  } coef_set_t;

  // Thousandths to fixed point with frac fraction bits, rounded to nearest
  function automatic coef_t scale_k(int milli, int frac);
    return coef_t'((milli * (1 << frac) + 500) / 1000);
  endfunction

  function automatic coef_set_t coef_lookup(csc_mode_e m, int frac);
    coef_set_t k;
    case (m)
      CSC_601_FULL: begin
        k.ky   =  scale_k(1000, frac);
        k.r_cr =  scale_k(1371, frac);
        k.g_cr = -scale_k(698, frac);
        k.g_cb = -scale_k(336, frac);
        k.b_cb =  scale_k(1732, frac);
      end
      CSC_601_STUDIO: begin
        k.ky   =  scale_k(1164, frac);
        k.r_cr =  scale_k(1596, frac);
        k.g_cr = -scale_k(813, frac);
        k.g_cb = -scale_k(391, frac);
        k.b_cb =  scale_k(2018, frac);
      end
      CSC_709_FULL: begin
        k.ky   =  scale_k(1000, frac);
        k.r_cr =  scale_k(1540, frac);
        k.g_cr = -scale_k(459, frac);
        k.g_cb = -scale_k(183, frac);
        k.b_cb =  scale_k(1816, frac);
      end
      default: begin
        k.ky   =  scale_k(1164, frac);
        k.r_cr =  scale_k(1793, frac);
        k.g_cr = -scale_k(534, frac);
        k.g_cb = -scale_k(213, frac);
        k.b_cb =  scale_k(2115, frac);
      end
    endcase
    return k;
  endfunction

endpackage

// File: rtl/ycc_front.sv
// Stage 1: offset removal and per-pixel coefficient capture
module ycc_front
  import ycc2rgb_pkg::*;
#(
  parameter int PIX_W  = 8,
  parameter int FRAC_W = 10
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic [PIX_W-1:0]        in_y,
  input  logic [PIX_W-1:0]        in_cb,
  input  logic [PIX_W-1:0]        in_cr,
  input  logic                    sel_709,
  input  logic                    sel_narrow,
  output logic                    s1_valid,
  output logic signed [PIX_W+1:0] s1_y,
  output logic signed [PIX_W:0]   s1_cb,
  output logic signed [PIX_W:0]   s1_cr,
  output coef_set_t               s1_k
);
  localparam logic signed [PIX_W+1:0] LUMA_OFS   = (PIX_W+2)'(16 << (PIX_W-8));
  localparam logic signed [PIX_W:0]   CHROMA_MID = (PIX_W+1)'(1 << (PIX_W-1));

  logic                    valid_nx;
  logic signed [PIX_W+1:0] y_nx;
  logic signed [PIX_W:0]   cb_nx;
  logic signed [PIX_W:0]   cr_nx;
  coef_set_t               k_nx;

  always_comb begin
    valid_nx = in_valid;
    y_nx     = $signed({2'b00, in_y}) - (sel_narrow ? LUMA_OFS : '0);
    cb_nx    = $signed({1'b0, in_cb}) - CHROMA_MID;
    cr_nx    = $signed({1'b0, in_cr}) - CHROMA_MID;
    k_nx     = coef_lookup(csc_mode_e'({sel_709, sel_narrow}), FRAC_W);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_y     <= '0;
      s1_cb    <= '0;
      s1_cr    <= '0;
      s1_k     <= '0;
    end else begin
      s1_valid <= valid_nx;
      if (in_valid) begin
        s1_y  <= y_nx;
        s1_cb <= cb_nx;
        s1_cr <= cr_nx;
        s1_k  <= k_nx;
      end
    end
  end
endmodule

// File: rtl/ycc_chan_mac.sv
// Stage 2: one output channel's multiply-accumulate
module ycc_chan_mac
  import ycc2rgb_pkg::*;
#(
  parameter int PIX_W = 8,
  parameter int ACC_W = 22
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  logic signed [PIX_W+1:0] y,
  input  logic signed [PIX_W:0]   cb,
  input  logic signed [PIX_W:0]   cr,
  input  coef_t                   k_y,
  input  coef_t                   k_cr,
  input  coef_t                   k_cb,
  output logic signed [ACC_W-1:0] acc
);
  localparam int SUM_W = COEF_W + PIX_W + 4;

  logic signed [SUM_W-1:0] sum;
  logic signed [ACC_W-1:0] acc_nx;

  always_comb begin
    sum = (SUM_W'(k_y)  * SUM_W'(y))
        + (SUM_W'(k_cr) * SUM_W'(cr))
        + (SUM_W'(k_cb) * SUM_W'(cb));
    acc_nx = sum[ACC_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc <= '0;
    else if (en) acc <= acc_nx;
  end
endmodule

// File: rtl/ycc_round_clamp.sv
// Stage 3: round to nearest, saturate to pixel range, hold output
module ycc_round_clamp #(
  parameter int PIX_W  = 8,
  parameter int FRAC_W = 10,
  parameter int ACC_W  = 22
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  logic signed [ACC_W-1:0] acc,
  output logic [PIX_W-1:0]        pix
);
  localparam logic signed [ACC_W-1:0] HALF    = ACC_W'(1 << (FRAC_W-1));
  localparam logic signed [ACC_W-1:0] PIX_MAX = ACC_W'((1 << PIX_W) - 1);

  logic signed [ACC_W-1:0] shifted;
  logic [PIX_W-1:0]        pix_nx;

  always_comb begin
    shifted = (acc + HALF) >>> FRAC_W;
    if (shifted < 0)            pix_nx = '0;
    else if (shifted > PIX_MAX) pix_nx = '1;
    else                        pix_nx = shifted[PIX_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pix <= '0;
    else if (en) pix <= pix_nx;
  end
endmodule

// File: rtl/ycc2rgb_conv.sv
module ycc2rgb_conv
  import ycc2rgb_pkg::*;
#(
  parameter int PIX_W  = 8,
  parameter int FRAC_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [PIX_W-1:0] in_y,
  input  logic [PIX_W-1:0] in_cb,
  input  logic [PIX_W-1:0] in_cr,
  input  logic             sel_709,
  input  logic             sel_narrow,
  output logic             out_valid,
  output logic [PIX_W-1:0] out_r,
  output logic [PIX_W-1:0] out_g,
  output logic [PIX_W-1:0] out_b
);
  localparam int ACC_W = PIX_W + FRAC_W + 4;
  localparam int NCH   = 3;

  logic                    s1_valid;
  logic signed [PIX_W+1:0] s1_y;
  logic signed [PIX_W:0]   s1_cb;
  logic signed [PIX_W:0]   s1_cr;
  coef_set_t               s1_k;

  coef_t                   k_cr [NCH];
  coef_t                   k_cb [NCH];
  logic signed [ACC_W-1:0] acc  [NCH];
  logic [PIX_W-1:0]        pix  [NCH];

  logic v2, v3, v2_nx, v3_nx;

  ycc_front #(.PIX_W(PIX_W), .FRAC_W(FRAC_W)) u_front (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .in_y(in_y), .in_cb(in_cb), .in_cr(in_cr),
    .sel_709(sel_709), .sel_narrow(sel_narrow),
    .s1_valid(s1_valid), .s1_y(s1_y), .s1_cb(s1_cb), .s1_cr(s1_cr), .s1_k(s1_k)
  );

  // Channel 0 = R (Cr only), 1 = G (both, negative), 2 = B (Cb only)
  always_comb begin
    k_cr[0] = s1_k.r_cr;  k_cb[0] = '0;
    k_cr[1] = s1_k.g_cr;  k_cb[1] = s1_k.g_cb;
    k_cr[2] = '0;         k_cb[2] = s1_k.b_cb;
  end

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    ycc_chan_mac #(.PIX_W(PIX_W), .ACC_W(ACC_W)) u_mac (
      .clk(clk), .rst_n(rst_n), .en(s1_valid),
      .y(s1_y), .cb(s1_cb), .cr(s1_cr),
      .k_y(s1_k.ky), .k_cr(k_cr[c]), .k_cb(k_cb[c]),
      .acc(acc[c])
    );
    ycc_round_clamp #(.PIX_W(PIX_W), .FRAC_W(FRAC_W), .ACC_W(ACC_W)) u_rc (
      .clk(clk), .rst_n(rst_n), .en(v2), .acc(acc[c]), .pix(pix[c])
    );
  end

  always_comb begin
    v2_nx = s1_valid;
    v3_nx = v2;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v2 <= 1'b0;
      v3 <= 1'b0;
    end else begin
      v2 <= v2_nx;
      v3 <= v3_nx;
    end
  end

  assign out_valid = v3;
  assign out_r     = pix[0];
  assign out_g     = pix[1];
  assign out_b     = pix[2];
endmodule

// File: rtl/ycc2rgb_chk.sv
module ycc2rgb_chk #(
  parameter int PIX_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [PIX_W-1:0] in_y,
  input logic [PIX_W-1:0] in_cb,
  input logic [PIX_W-1:0] in_cr,
  input logic             sel_narrow,
  input logic             out_valid,
  input logic [PIX_W-1:0] out_r,
  input logic [PIX_W-1:0] out_g,
  input logic [PIX_W-1:0] out_b
);
  localparam logic [PIX_W-1:0] MID = PIX_W'(1 << (PIX_W-1));

  // Edges since reset release, saturating at 3, so $past(...,3) never reaches into reset
  logic [1:0] seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen <= 2'd0;
    else if (seen != 2'd3) seen <= seen + 2'd1;
  end

  always @(posedge clk) begin
    if (!rst_n) assert_idle_in_reset_R1: assert (!out_valid);
  end

  assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (seen == 2'd3) |-> (out_valid == $past(in_valid, 3)));

  assert_neutral_grey_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((seen == 2'd3) && $past(in_valid && in_cb == MID && in_cr == MID, 3))
    |-> (out_r == out_g && out_g == out_b));

  assert_full_luma_pass_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((seen == 2'd3) && $past(in_valid && !sel_narrow && in_cb == MID && in_cr == MID, 3))
    |-> (out_r == $past(in_y, 3)));

  assert_hold_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> ($stable(out_r) && $stable(out_g) && $stable(out_b)));
endmodule

bind ycc2rgb_conv ycc2rgb_chk #(.PIX_W(PIX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
  .in_y(in_y), .in_cb(in_cb), .in_cr(in_cr), .sel_narrow(sel_narrow),
  .out_valid(out_valid), .out_r(out_r), .out_g(out_g), .out_b(out_b)
);

// File: tb/ycc2rgb_conv_test.sv
module ycc2rgb_conv_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_y = '0, in_cb = '0, in_cr = '0;
  logic       sel_709 = 1'b0, sel_narrow = 1'b0;
  logic       out_valid;
  logic [7:0] out_r, out_g, out_b;

  int checks = 0;
  int fails  = 0;
  int cur_tag = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;   // 125 MHz

  ycc2rgb_conv uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .in_y(in_y), .in_cb(in_cb), .in_cr(in_cr),
    .sel_709(sel_709), .sel_narrow(sel_narrow),
    .out_valid(out_valid), .out_r(out_r), .out_g(out_g), .out_b(out_b)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int sat8(input int v, inout bit clip);
    if (v < 0)   begin clip = 1'b1; return 0;   end
    if (v > 255) begin clip = 1'b1; return 255; end
    return v;
  endfunction

  // Integer model; mode m = {sel_709, sel_narrow}
  function automatic void ref_pix(input int y, input int cb, input int cr, input int m,
                                  output int r, output int g, output int b, output bit clip);
    int ky, yo, rcr, gcr, gcb, bcb;
    case (m)
      0: begin ky = 1024; yo = 0;  rcr = 1404; gcr = 715; gcb = 344; bcb = 1774; end
      1: begin ky = 1192; yo = 16; rcr = 1634; gcr = 833; gcb = 400; bcb = 2066; end
      2: begin ky = 1024; yo = 0;  rcr = 1577; gcr = 470; gcb = 187; bcb = 1860; end
      default: begin ky = 1192; yo = 16; rcr = 1836; gcr = 547; gcb = 218; bcb = 2166; end
    endcase
    clip = 1'b0;
    r = sat8((ky*(y-yo) + rcr*(cr-128) + 512) >>> 10, clip);
    g = sat8((ky*(y-yo) - gcr*(cr-128) - gcb*(cb-128) + 512) >>> 10, clip);
    b = sat8((ky*(y-yo) + bcb*(cb-128) + 512) >>> 10, clip);
  endfunction

  // Expected pipeline, advanced at each falling edge
  bit pv [1:3];
  int py [1:3], pcb [1:3], pcr [1:3], pm [1:3], ptag [1:3];
  int lr = 0, lg = 0, lb = 0;

  always @(negedge clk) begin
    if (!rst_n) begin
      for (int k = 1; k <= 3; k++) pv[k] = 1'b0;
      lr = 0; lg = 0; lb = 0;
    end else begin
      for (int k = 3; k >= 2; k--) begin
        pv[k] = pv[k-1]; py[k] = py[k-1]; pcb[k] = pcb[k-1];
        pcr[k] = pcr[k-1]; pm[k] = pm[k-1]; ptag[k] = ptag[k-1];
      end
      pv[1] = in_valid; py[1] = in_y; pcb[1] = in_cb; pcr[1] = in_cr;
      pm[1] = {sel_709, sel_narrow}; ptag[1] = cur_tag;
      chk("R2 out_valid", int'(out_valid), int'(pv[3]));
      if (pv[3]) begin
        int er, eg, eb;
        bit clip;
        string t;
        ref_pix(py[3], pcb[3], pcr[3], pm[3], er, eg, eb, clip);
        if (ptag[3] == 10)  t = "R10";
        else if (clip)      t = "R9";
        else case (pm[3])
          0: t = "R3";
          1: t = "R4";
          2: t = "R5";
          default: t = "R6";
        endcase
        chk({t, " red"}, out_r, er);
        chk({t, " green"}, out_g, eg);
        chk({t, " blue"}, out_b, eb);
        lr = er; lg = eg; lb = eb;
      end else begin
        chk("R11 hold red", out_r, lr);
        chk("R11 hold green", out_g, lg);
        chk("R11 hold blue", out_b, lb);
      end
    end
  end

  task automatic drive(input bit v, input int y, input int cb, input int cr, input int m);
    @(negedge clk);
    #1;
    in_valid = v; in_y = 8'(y); in_cb = 8'(cb); in_cr = 8'(cr);
    sel_709 = m[1]; sel_narrow = m[0];
  endtask

  // One pixel followed by idle; returns the result three edges later
  task automatic one(input int y, input int cb, input int cr, input int m,
                     output int r, output int g, output int b);
    drive(1, y, cb, cr, m);
    drive(0, y, cb, cr, m);
    @(negedge clk);
    @(negedge clk);
    r = out_r; g = out_g; b = out_b;
  endtask

  task automatic t_reset();
    repeat (4) begin
      @(negedge clk);
      chk("R1 out_valid in reset", int'(out_valid), 0);
    end
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) begin
      @(negedge clk);
      chk("R1 out_valid after reset", int'(out_valid), 0);
    end
  endtask

  task automatic t_neutral();
    int r, g, b;
    for (int m = 0; m < 4; m++) begin
      one(77, 128, 128, m, r, g, b);
      chk("R7 grey r==g", r, g);
      chk("R7 grey g==b", g, b);
    end
    one(77, 128, 128, 0, r, g, b);
    chk("R7 full-range luma pass", r, 77);
    one(200, 128, 128, 2, r, g, b);
    chk("R7 full-range luma pass 709", g, 200);
    one(16, 128, 128, 1, r, g, b);
    chk("R4 studio black", r, 0);
    one(235, 128, 128, 3, r, g, b);
    chk("R6 studio white", b, 255);
  endtask

  task automatic t_limits();
    int ys [6] = '{0, 16, 235, 255, 1, 254};
    int r, g, b;
    for (int m = 0; m < 4; m++)
      for (int i = 0; i < 6; i++) one(ys[i], 128, 128, m, r, g, b);
    one(255, 128, 128, 0, r, g, b);
    chk("R3 full white", r, 255);
    one(0, 128, 128, 2, r, g, b);
    chk("R5 full black", g, 0);
  endtask

  task automatic t_rounding();
    int r, g, b;
    // B = 100 + 1774/1024 = 101.73 -> 102; G = 100 - 344/1024 = 99.66 -> 100
    one(100, 129, 128, 0, r, g, b);
    chk("R8 round up blue", b, 102);
    chk("R8 round up green", g, 100);
    // R = 100 + 1404/1024 = 101.37 -> 101
    one(100, 128, 129, 0, r, g, b);
    chk("R8 round down red", r, 101);
  endtask

  task automatic t_chroma_extremes();
    int cv [2] = '{0, 255};
    int yv [3] = '{0, 128, 255};
    int r, g, b;
    for (int m = 0; m < 4; m++)
      for (int i = 0; i < 3; i++)
        for (int j = 0; j < 2; j++)
          for (int k = 0; k < 2; k++)
            drive(1, yv[i], cv[j], cv[k], m);
    drive(0, 0, 128, 128, 0);
    repeat (3) @(negedge clk);
    one(255, 128, 255, 0, r, g, b);
    chk("R9 saturate high red", r, 255);
    one(0, 128, 0, 0, r, g, b);
    chk("R9 saturate low red", r, 0);
    one(0, 255, 128, 3, r, g, b);
    chk("R9 saturate low green", g, 0);
  endtask

  task automatic t_random();
    for (int m = 0; m < 4; m++) begin
      for (int n = 0; n < 300; n++)
        drive($urandom_range(4, 0) != 0, $urandom_range(255, 0),
              $urandom_range(255, 0), $urandom_range(255, 0), m);
      drive(0, 0, 0, 0, m);
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic t_mode_switch();
    int r, g, b, er, eg, eb;
    bit clip;
    cur_tag = 10;   // R10: every pixel carries its own mode
    for (int n = 0; n < 64; n++)
      drive(1, 60 + n, 90 + n, 200 - n, n % 4);
    drive(0, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    cur_tag = 0;
    // Mode changed on the cycle after the pixel must not alter it
    drive(1, 150, 60, 210, 1);
    drive(0, 150, 60, 210, 2);
    @(negedge clk);
    @(negedge clk);
    r = out_r; g = out_g; b = out_b;
    ref_pix(150, 60, 210, 1, er, eg, eb, clip);
    chk("R10 mode sampled with pixel red", r, er);
    chk("R10 mode sampled with pixel blue", b, eb);
  endtask

  task automatic t_hold();
    int r, g, b;
    one(180, 40, 220, 2, r, g, b);
    for (int n = 0; n < 12; n++) begin
      drive(0, $urandom_range(255, 0), $urandom_range(255, 0),
            $urandom_range(255, 0), n % 4);
      chk("R11 idle red", out_r, r);
      chk("R11 idle green", out_g, g);
      chk("R11 idle blue", out_b, b);
    end
  endtask

  initial begin
    t_reset();
    t_neutral();
    t_limits();
    t_rounding();
    t_chroma_extremes();
    t_random();
    t_mode_switch();
    t_hold();
    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule